// File: doc/BRIEF.md
# Event-Driven Output Bit Controller

This block holds the 32 output bits of one port group and lets hardware events change single bits without a software write. A parameterised number of event channels (four by default) watch single-cycle event pulses. Each channel is set up by one byte of a control word. When an enabled channel sees a pulse, it applies its action to the output bit it points at. The action drives the bit to the event's level, forces it high, forces it low, or inverts it.

Software reaches the block through a write port with one select bit. The select bit chooses either the control word or the output word. The control word is always visible on its own output port. A chip with several port groups places one instance per group. Each instance holds its own control and output state.

Top module: `evg_event_out`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pins_out` and `ctrl_q` are all zeros, so every channel starts disabled.
- R2: A write with `wr_sel`=0 loads the whole `wr_data` word into the control word, visible on `ctrl_q` after that clock edge. A write with `wr_sel`=1 loads `wr_data` into the output bits, visible on `pins_out` after that edge.
- R3: Channel c is configured by `ctrl_q[8c+7:8c]`. Within that byte, bit 7 enables the channel, bits 6:5 hold the action code and bits 4:0 give the target bit number, 0 to 31.
- R4: A pulse on a channel whose enable bit is 0 leaves `pins_out` unchanged.
- R5: Action code 0 writes `evt_level[c]` into the target bit.
- R6: Action code 1 sets the target bit to 1. Action code 2 clears it to 0.
- R7: Action code 3 makes the target bit the inverse of the value it held before the clock edge.
- R8: When several enabled channels pulse on the same target bit in one cycle, the channel with the highest number decides the result.
- R9: Enabled channels that pulse on different target bits in the same cycle all take effect in that cycle.
- R10: When an output-word write and an enabled event hit in the same cycle, the targeted bit takes the event result and every other bit takes the written value.
- R11: An event sampled at a clock edge shows on `pins_out` right after that edge. A control write applies to events from the next edge onward, so an event in the same cycle as the write still uses the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, clears both words |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 1 | Write target: 0 for the control word, 1 for the output word |
| wr_data | input | 32 | Write data |
| evt_pulse | input | 4 | One single-cycle event pulse per channel |
| evt_level | input | 4 | Event level per channel, used by action code 0 |
| ctrl_q | output | 32 | Current control word |
| pins_out | output | 32 | Current output bits |

## Verification
Every result is due exactly one rising edge after its stimulus. This covers the output bits after an event or output write, and the control word after a control write. A new configuration first acts on events driven in the cycle after its write. The driver applies each stimulus on a falling edge. It pushes the state a requirement-level model predicts after the next rising edge into a queue. The monitor pops and compares two nanoseconds after each rising edge, so each expectation meets exactly the edge that should produce it.

// File: rtl/evg_pkg.sv
package evg_pkg;

   // Width of one channel's configuration byte and of its target field.
   localparam int unsigned CFG_BYTE_W = 8;
   localparam int unsigned CFG_SEL_W  = 5;

   // Action codes; the encoding is fixed by the byte layout.
   typedef enum logic [1:0] {
      EVG_ACT_LEVEL = 2'd0,
      EVG_ACT_SET   = 2'd1,
      EVG_ACT_CLEAR = 2'd2,
      EVG_ACT_FLIP  = 2'd3
   } evg_act_e;

   // One channel's configuration, msb first: enable, action, target.
   typedef struct packed {
      logic                 en;
      evg_act_e             act;
      logic [CFG_SEL_W-1:0] sel;
   } evg_cfg_t;

endpackage

// File: rtl/evg_cfg_reg.sv
module evg_cfg_reg
   import evg_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned BUS_W  = 32,
   localparam int unsigned CTRL_W = NUM_CH * CFG_BYTE_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_ctrl,
   input  logic [BUS_W-1:0]               wr_data,
   output logic [CTRL_W-1:0]              ctrl_q,
   output evg_cfg_t [NUM_CH-1:0]          cfg_o
);

   // One byte register per channel.
   for (genvar c = 0; c < NUM_CH; c++) begin : g_byte
      logic [CFG_BYTE_W-1:0] byte_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (wr_ctrl) begin
            byte_q <= wr_data[c*CFG_BYTE_W +: CFG_BYTE_W];
         end
      end

      assign ctrl_q[c*CFG_BYTE_W +: CFG_BYTE_W] = byte_q;
      assign cfg_o[c]                          = evg_cfg_t'(byte_q);
   end

   // Bus bits above the control word are not stored.
   if (BUS_W > CTRL_W) begin : g_wide_bus
      logic unused_hi;
      assign unused_hi = ^wr_data[BUS_W-1:CTRL_W];
   end

endmodule

// File: rtl/evg_chan_decode.sv
module evg_chan_decode
   import evg_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   localparam int unsigned PIN_W   = $clog2(NUM_PINS)
) (
   input  evg_cfg_t              cfg,
   input  logic                  pulse,
   input  logic                  level,
   input  logic [NUM_PINS-1:0]   cur,
   output logic [NUM_PINS-1:0]   hit,
   output logic                  val
);

   logic sel_ok;
   logic fire;

   // A full group decodes every target value; a narrow one drops out-of-range targets.
   if (NUM_PINS == (1 << CFG_SEL_W)) begin : g_full_sel
      assign sel_ok = 1'b1;
   end else begin : g_narrow_sel
      assign sel_ok = (cfg.sel < CFG_SEL_W'(NUM_PINS));
   end

   assign fire = cfg.en & pulse & sel_ok;

   // One-hot target mask.
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign hit[p] = fire && (cfg.sel == CFG_SEL_W'(p));
   end

   // New value of the targeted bit.
   always_comb begin
      unique case (cfg.act)
         EVG_ACT_LEVEL: val = level;
         EVG_ACT_SET:   val = 1'b1;
         EVG_ACT_CLEAR: val = 1'b0;
         EVG_ACT_FLIP:  val = ~cur[cfg.sel[PIN_W-1:0]];
         default:       val = 1'b0;
      endcase
   end

endmodule

// File: rtl/evg_out_merge.sv
module evg_out_merge #(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned NUM_CH   = 4,
   localparam int unsigned HIT_W   = NUM_PINS * NUM_CH
) (
   input  logic [NUM_PINS-1:0] cur,
   input  logic                bus_load,
   input  logic [NUM_PINS-1:0] bus_val,
   input  logic [HIT_W-1:0]    hit_vec,
   input  logic [NUM_CH-1:0]   val_vec,
   output logic [NUM_PINS-1:0] nxt
);

   // Channel 0 is applied first, so the highest channel lands last and wins.
   always_comb begin
      nxt = bus_load ? bus_val : cur;
      for (int c = 0; c < NUM_CH; c++) begin
         nxt = (nxt & ~hit_vec[c*NUM_PINS +: NUM_PINS])
             | (hit_vec[c*NUM_PINS +: NUM_PINS] & {NUM_PINS{val_vec[c]}});
      end
   end

endmodule

// File: rtl/evg_event_out.sv
module evg_event_out
   import evg_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned BUS_W    = 32,
   localparam int unsigned CTRL_W  = NUM_CH * CFG_BYTE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_sel,
   input  logic [BUS_W-1:0]    wr_data,
   input  logic [NUM_CH-1:0]   evt_pulse,
   input  logic [NUM_CH-1:0]   evt_level,
   output logic [CTRL_W-1:0]   ctrl_q,
   output logic [NUM_PINS-1:0] pins_out
);

   // Elaboration-time parameter checks.
   if (NUM_CH < 1 || CTRL_W > BUS_W) begin : g_bad_ch
      $error("evg_event_out: NUM_CH must be 1 or more and fit the bus width");
   end
   if (NUM_PINS < 2 || NUM_PINS > (1 << CFG_SEL_W) || NUM_PINS > BUS_W) begin : g_bad_pins
      $error("evg_event_out: NUM_PINS must be 2..32 and fit the bus width");
   end
   if (NUM_PINS != (1 << $clog2(NUM_PINS))) begin : g_bad_pow2
      $error("evg_event_out: NUM_PINS must be a power of two");
   end

   evg_cfg_t [NUM_CH-1:0]       cfg;
   logic [NUM_PINS*NUM_CH-1:0]  hit_vec;
   logic [NUM_CH-1:0]           val_vec;
   logic [NUM_PINS-1:0]         out_q;
   logic [NUM_PINS-1:0]         out_d;
   logic                        wr_ctrl;
   logic                        wr_out;

   assign wr_ctrl = wr_en & ~wr_sel;
   assign wr_out  = wr_en &  wr_sel;

   evg_cfg_reg #(
      .NUM_CH (NUM_CH),
      .BUS_W  (BUS_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_data (wr_data),
      .ctrl_q  (ctrl_q),
      .cfg_o   (cfg)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      evg_chan_decode #(
         .NUM_PINS (NUM_PINS)
      ) u_dec (
         .cfg   (cfg[c]),
         .pulse (evt_pulse[c]),
         .level (evt_level[c]),
         .cur   (out_q),
         .hit   (hit_vec[c*NUM_PINS +: NUM_PINS]),
         .val   (val_vec[c])
      );
   end

   evg_out_merge #(
      .NUM_PINS (NUM_PINS),
      .NUM_CH   (NUM_CH)
   ) u_merge (
      .cur      (out_q),
      .bus_load (wr_out),
      .bus_val  (wr_data[NUM_PINS-1:0]),
      .hit_vec  (hit_vec),
      .val_vec  (val_vec),
      .nxt      (out_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
      end else begin
         out_q <= out_d;
      end
   end

   assign pins_out = out_q;

endmodule

// File: rtl/evg_event_out_chk.sv
module evg_event_out_chk #(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned BUS_W    = 32,
   localparam int unsigned CTRL_W  = NUM_CH * 8,
   localparam int unsigned PIN_W   = $clog2(NUM_PINS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                wr_sel,
   input logic [BUS_W-1:0]    wr_data,
   input logic [NUM_CH-1:0]   evt_pulse,
   input logic [NUM_CH-1:0]   evt_level,
   input logic [CTRL_W-1:0]   ctrl_q,
   input logic [NUM_PINS-1:0] pins_out
);

   logic [NUM_CH-1:0] en_vec;
   logic              any_fire;
   logic [7:0]        top_byte;
   logic              top_fire;
   logic [PIN_W-1:0]  top_pin;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_en
      assign en_vec[c] = ctrl_q[8*c+7];
   end

   assign any_fire = |(evt_pulse & en_vec);
   assign top_byte = ctrl_q[8*(NUM_CH-1) +: 8];
   assign top_pin  = top_byte[PIN_W-1:0];
   assign top_fire = top_byte[7] && evt_pulse[NUM_CH-1]
                     && (int'(top_byte[4:0]) < NUM_PINS);

   // R1: both words are clear on the first cycle out of reset
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pins_out == '0 && ctrl_q == '0));

   // R2: a control write shows on the control port one edge later
   p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> ctrl_q == $past(wr_data[CTRL_W-1:0]));

   // R10: an output write with no enabled event lands unchanged
   p_out_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && !any_fire) |=> pins_out == $past(wr_data[NUM_PINS-1:0]));

   // R4: without a write or enabled event the outputs hold
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && wr_sel) && !any_fire) |=> pins_out == $past(pins_out));

   // R5: level action on the highest channel copies the event level
   p_level_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (top_fire && top_byte[6:5] == 2'd0) |=> pins_out[$past(top_pin)] == $past(evt_level[NUM_CH-1]));

   // R6: set and clear on the highest channel force the bit
   p_set_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (top_fire && top_byte[6:5] == 2'd1) |=> pins_out[$past(top_pin)] == 1'b1);
   p_clear_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (top_fire && top_byte[6:5] == 2'd2) |=> pins_out[$past(top_pin)] == 1'b0);

   // R7: flip on the highest channel inverts the old bit value
   p_flip_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (top_fire && top_byte[6:5] == 2'd3) |=> pins_out[$past(top_pin)] != $past(pins_out[top_pin]));

endmodule

bind evg_event_out evg_event_out_chk #(
   .NUM_PINS (NUM_PINS),
   .NUM_CH   (NUM_CH),
   .BUS_W    (BUS_W)
) u_evg_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .evt_pulse (evt_pulse),
   .evt_level (evt_level),
   .ctrl_q    (ctrl_q),
   .pins_out  (pins_out)
);

// File: tb/test_evg_event_out.sv
`timescale 1ns/1ps
module test_evg_event_out;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic [3:0]  evt_pulse = '0;
   logic [3:0]  evt_level = '0;
   logic [31:0] ctrl_q;
   logic [31:0] pins_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   logic [31:0] m_out  = '0;
   logic [31:0] m_ctrl = '0;

   logic [31:0] q_out[$];
   logic [31:0] q_ctrl[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   evg_event_out i_evg_event_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .evt_pulse (evt_pulse),
      .evt_level (evt_level),
      .ctrl_q    (ctrl_q),
      .pins_out  (pins_out)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: apply one cycle of stimulus and queue the state due after the next edge.
   task automatic step(input logic we, input logic sel, input logic [31:0] d,
                       input logic [3:0] pls, input logic [3:0] lvl, input string tag);
      logic [31:0] nxt;
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_data = d; evt_pulse = pls; evt_level = lvl;
      nxt = (we && sel) ? d : m_out;
      for (int c = 0; c < 4; c++) begin
         logic [7:0] b;
         b = m_ctrl[8*c +: 8];
         if (b[7] && pls[c]) begin
            case (b[6:5])
               2'd0: nxt[b[4:0]] = lvl[c];
               2'd1: nxt[b[4:0]] = 1'b1;
               2'd2: nxt[b[4:0]] = 1'b0;
               default: nxt[b[4:0]] = ~m_out[b[4:0]];
            endcase
         end
      end
      if (we && !sel) m_ctrl = d;
      m_out = nxt;
      q_out.push_back(m_out);
      q_ctrl.push_back(m_ctrl);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'h0, 4'h0, 4'h0, tag);
   endtask

   // Monitor: compare two nanoseconds after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_out.size() > 0) begin
            string t;
            logic [31:0] eo;
            logic [31:0] ec;
            eo = q_out.pop_front();
            ec = q_ctrl.pop_front();
            t  = q_tag.pop_front();
            check(pins_out, eo, {t, " pins_out"});
            check(ctrl_q, ec, {t, " ctrl_q"});
         end
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R1: state while reset is held
      repeat (3) @(negedge clk);
      check(pins_out, 32'h0, "R1 in reset pins_out");
      check(ctrl_q, 32'h0, "R1 in reset ctrl_q");
      rst_n = 1'b1;
      idle(2, "R1");

      // R4: disabled channels with pulses on an all-zero control word
      step(1'b0, 1'b0, 32'h0, 4'hF, 4'hF, "R4");

      // R2: full-word writes to both registers
      step(1'b1, 1'b0, 32'h1234_5678, 4'h0, 4'h0, "R2");
      step(1'b1, 1'b1, 32'hA5A5_0F0F, 4'h0, 4'h0, "R2");
      // R4: actions configured but enables low (bit 7 of each byte clear)
      step(1'b1, 1'b0, 32'h6321_4303, 4'h0, 4'h0, "R4");
      step(1'b0, 1'b0, 32'h0, 4'hF, 4'hF, "R4");
      step(1'b0, 1'b0, 32'h0, 4'hF, 4'h0, "R4");

      // R3/R5: channel 0 level action on bit 3 (byte 0x83)
      step(1'b1, 1'b1, 32'h0, 4'h0, 4'h0, "R2");
      step(1'b1, 1'b0, 32'h0000_0083, 4'h0, 4'h0, "R3");
      step(1'b0, 1'b0, 32'h0, 4'h1, 4'h1, "R5");
      step(1'b0, 1'b0, 32'h0, 4'h1, 4'h0, "R5");
      step(1'b0, 1'b0, 32'h0, 4'h0, 4'h1, "R4");

      // R6: channel 1 set bit 10 (0xAA), channel 2 clear bit 0 (0xC0)
      step(1'b1, 1'b1, 32'h0000_0001, 4'h0, 4'h0, "R2");
      step(1'b1, 1'b0, 32'h00C0_AA00, 4'h0, 4'h0, "R3");
      step(1'b0, 1'b0, 32'h0, 4'h2, 4'h0, "R6");
      step(1'b0, 1'b0, 32'h0, 4'h4, 4'h0, "R6");
      step(1'b0, 1'b0, 32'h0, 4'h1, 4'h1, "R4");

      // R7: channel 3 flip bit 31 (0xFF), twice
      step(1'b1, 1'b0, 32'hFF00_0000, 4'h0, 4'h0, "R3");
      step(1'b0, 1'b0, 32'h0, 4'h8, 4'h0, "R7");
      step(1'b0, 1'b0, 32'h0, 4'h8, 4'h0, "R7");
      step(1'b0, 1'b0, 32'h0, 4'h8, 4'h8, "R7");

      // R8: channel 0 sets bit 5, channel 3 clears it; then reversed
      step(1'b1, 1'b1, 32'h0, 4'h0, 4'h0, "R2");
      step(1'b1, 1'b0, 32'hC500_00A5, 4'h0, 4'h0, "R3");
      step(1'b0, 1'b0, 32'h0, 4'h9, 4'h0, "R8");
      step(1'b1, 1'b0, 32'hA500_00C5, 4'h0, 4'h0, "R3");
      step(1'b0, 1'b0, 32'h0, 4'h9, 4'h0, "R8");

      // R9: four channels on four bits in one cycle
      step(1'b1, 1'b1, 32'h0000_0F00, 4'h0, 4'h0, "R2");
      step(1'b1, 1'b0, 32'hFE_C9_A4_81, 4'h0, 4'h0, "R3");
      step(1'b0, 1'b0, 32'h0, 4'hF, 4'h1, "R9");

      // R10: output write with an event on bit 4 (channel 1 sets bit 4)
      step(1'b1, 1'b1, 32'hFFFF_0000, 4'h2, 4'h0, "R10");
      step(1'b1, 1'b0, 32'h0000_C400, 4'h0, 4'h0, "R3");
      step(1'b1, 1'b1, 32'h0000_FFFF, 4'h2, 4'h0, "R10");

      // R11: event in the write cycle uses the old word (channel 1 clears bit 4)
      step(1'b1, 1'b1, 32'h0000_0010, 4'h0, 4'h0, "R2");
      step(1'b1, 1'b0, 32'h0000_A400, 4'h2, 4'h0, "R11");
      step(1'b0, 1'b0, 32'h0, 4'h2, 4'h0, "R11");

      // Mixed traffic with enabled channels
      for (int i = 0; i < 400; i++) begin
         logic [31:0] d;
         logic [1:0]  k;
         d = $urandom;
         k = 2'($urandom_range(0, 3));
         if (k == 2'd0) d = d | 32'h8080_8080;
         step(k != 2'd3, k[0], d, 4'($urandom), 4'($urandom), "R9 mixed");
      end

      idle(3, "R4");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule